// File: doc/BRIEF.md
# Two-Wire Slave with Pointer-Addressed Registers

This block is a slave on a two-wire serial bus (SMBus/I2C style). It lets a bus master read and write a small register file. The block samples the clock line and the data line with the system clock. From those samples it finds start and stop conditions, clock edges and data bits. It answers to one 7-bit address, whose low three bits come from strap inputs. It drives the data line only as an open-drain pull-down enable.

A stored 2-bit pointer picks one of four registers, and it keeps its value from one transaction to the next:

| Pointer | Register | Width | Access |
|---|---|---|---|
| 0 | sample register, fed from `sample_i` | 16 bits | read-only |
| 1 | configuration register | 8 bits | read/write |
| 2 | threshold A | 16 bits | read/write |
| 3 | threshold B | 16 bits | read/write |

A write transaction always carries the pointer byte first, then the data bytes. A read transaction uses whatever the pointer last held. Sixteen-bit registers go over the bus high byte first.

Data flows in and out only on the serial bus. The block has no valid/ready stream port and no back-pressure path. It never stretches the clock, so the master sets the pace and the slave must keep up with every bit.

Top module: `smb_ptr_slave`

## Requirements
- R1: The first byte after a start is the address: bits 7..1 are compared with {4'b1001, strap_i}, and bit 0 is read/write (0 = write, 1 = read). On a match the slave ACKs in the ninth clock. On a mismatch it leaves SDA released until the next start or stop.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A stop returns the slave to idle with SDA released.
- R3: `sda_oe_o` = 1 pulls SDA low. It changes only after a detected SCL falling edge, or on a start or stop. Incoming bits are taken on SCL rising edges, most significant bit first.
- R4: In a write transaction the byte after the address is the pointer byte. When its bits 7..2 are all zero, bits 1..0 are stored as the pointer and the byte is ACKed.
- R5: A pointer byte with any of bits 7..2 set is NACKed. The transaction is abandoned (later bytes are NACKed) and the stored pointer is unchanged.
- R6: The pointer persists across stops and repeated starts. A read transaction with no pointer cycle returns the register last pointed to.
- R7: A read of a 16-bit register sends the high byte first, then the low byte after a master ACK. The configuration register is a one-byte read. If the master ACKs the last byte, the slave drives nothing more, so the next clocked byte reads as 0xFF.
- R8: A master NACK ends a read. The slave releases SDA and stays off the bus until the next start.
- R9: Each data byte after the pointer is ACKed. Threshold registers take the high byte first and then the low byte. The configuration register takes one byte. Bytes beyond the register width are ACKed and discarded.
- R10: Pointer 0 reads the current `sample_i`. Writes to pointer 0 are ACKed and change nothing.
- R11: A start or stop in the middle of a byte abandons that byte. A start then begins a new address phase and keeps the pointer.
- R12: Both bytes of a 16-bit read come from one snapshot, taken when the high byte is loaded. A change of the source before the low byte is sent does not show in that read.
- R13: After reset: `sda_oe_o` = 0, pointer = 0, configuration = 0x00, threshold A = 0x4B00, threshold B = 0x5000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock that samples the bus |
| rst_n | input | 1 | asynchronous active-low reset |
| scl_i | input | 1 | bus clock line as seen at the pin |
| sda_i | input | 1 | bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | low three bits of the slave address |
| sample_i | input | 16 | source of the read-only sample register |
| cfg_o | output | 8 | configuration register contents |
| thr_a_o | output | 16 | threshold A contents |
| thr_b_o | output | 16 | threshold B contents |

## Verification
The main function is exercised with several kinds of transaction:
- **Reads without a pointer cycle**, right after reset and after later writes. These separate pointer persistence from pointer loading.
- **A pointer write followed by a repeated-start read.** This shows that a new address phase does not disturb the pointer.
- **Reads that end differently**: one-byte reads, two-byte reads ended by a master NACK, and two-byte reads where the master ACKs past the last byte. These tell the byte count per register apart from the master's choice to continue.
- **Corner cases**: bad pointer bytes, a foreign address, aborts in mid-byte, surplus write bytes, writes to the read-only register, and a change of the sample source during a read. Each shows whether state is kept or discarded in exactly the case its requirement names.

// File: rtl/smbp_pkg.sv
package smbp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 2;
  localparam logic [3:0] ADDR_HI = 4'b1001;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PTR,
    PH_WR,
    PH_RD
  } phase_t;

  // number of bus bytes carried by the register a pointer selects
  function automatic logic [1:0] reg_bytes(input logic [PTR_W-1:0] p);
    return (p == 2'd1) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/smbp_lines.sv
module smbp_lines #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = SYNC_STAGES - 1;

  // each stage holds {scl, sda}
  logic [1:0] stg [SYNC_STAGES];
  logic [1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) stg[k] <= 2'b11;
      prev <= 2'b11;
    end else begin
      stg[0] <= {scl_i, sda_i};
      for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
      prev <= stg[LAST];
    end
  end

  logic scl_c, sda_c, scl_p, sda_p;
  assign scl_c = stg[LAST][1];
  assign sda_c = stg[LAST][0];
  assign scl_p = prev[1];
  assign sda_p = prev[0];

  assign sda_s     = sda_c;
  assign scl_rise  = scl_c & ~scl_p;
  assign scl_fall  = ~scl_c & scl_p;
  assign start_det = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_det  = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/smbp_engine.sv
module smbp_engine
  import smbp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [2:0]           strap_i,
  input  logic [WORD_W-1:0]    rd_word,
  output logic                 sda_oe,
  output logic [PTR_W-1:0]     ptr,
  output logic                 wr_en,
  output logic                 wr_idx,
  output logic [BYTE_W-1:0]    wr_data
);
  localparam logic [3:0] BITS = 4'd8;

  phase_t              phase;
  logic [3:0]          bit_cnt;
  logic                ack_slot;
  logic [BYTE_W-1:0]   shreg;
  logic [BYTE_W-1:0]   tx;
  logic [1:0]          byte_idx;
  logic                mst_ack;
  logic [WORD_W-1:0]   snap;
  logic [BYTE_W-1:0]   next_byte;

  // first byte comes live from the register; the second from the snapshot
  always_comb begin
    if (byte_idx == 2'd0)
      next_byte = (ptr == 2'd1) ? rd_word[BYTE_W-1:0] : rd_word[WORD_W-1:BYTE_W];
    else
      next_byte = snap[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      ack_slot <= 1'b0;
      shreg    <= '0;
      tx       <= '0;
      byte_idx <= '0;
      mst_ack  <= 1'b0;
      snap     <= '0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      wr_en    <= 1'b0;
      wr_idx   <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det || stop_det) begin
        phase    <= start_det ? PH_ADDR : PH_IDLE;
        bit_cnt  <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (scl_rise) begin
        if (ack_slot) begin
          if (phase == PH_RD && byte_idx != 2'd0) mst_ack <= ~sda_s;
        end else if (phase != PH_IDLE && bit_cnt != BITS) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (ack_slot) begin
          // end of the ninth clock
          ack_slot <= 1'b0;
          bit_cnt  <= '0;
          sda_oe   <= 1'b0;
          if (phase == PH_RD) begin
            if (mst_ack && byte_idx < reg_bytes(ptr)) begin
              tx       <= next_byte;
              sda_oe   <= ~next_byte[BYTE_W-1];
              byte_idx <= byte_idx + 2'd1;
              if (byte_idx == 2'd0) snap <= rd_word;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end else if (bit_cnt == BITS) begin
          // start of the ninth clock
          ack_slot <= 1'b1;
          unique case (phase)
            PH_ADDR: begin
              if (shreg[BYTE_W-1:1] == {ADDR_HI, strap_i}) begin
                sda_oe   <= 1'b1;
                byte_idx <= '0;
                mst_ack  <= 1'b1;
                phase    <= shreg[0] ? PH_RD : PH_PTR;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_PTR: begin
              if (shreg[BYTE_W-1:PTR_W] == '0) begin
                ptr      <= shreg[PTR_W-1:0];
                sda_oe   <= 1'b1;
                byte_idx <= '0;
                phase    <= PH_WR;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_WR: begin
              sda_oe <= 1'b1;
              if (byte_idx < reg_bytes(ptr)) begin
                wr_en    <= 1'b1;
                wr_idx   <= byte_idx[0];
                wr_data  <= shreg;
                byte_idx <= byte_idx + 2'd1;
              end
            end
            PH_RD:   sda_oe <= 1'b0;
            default: phase  <= PH_IDLE;
          endcase
        end else if (phase == PH_RD) begin
          tx     <= {tx[BYTE_W-2:0], 1'b0};
          sda_oe <= ~tx[BYTE_W-2];
        end
      end
    end
  end
endmodule

// File: rtl/smbp_regs.sv
module smbp_regs
  import smbp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RST = 8'h00,
  parameter logic [WORD_W-1:0] THA_RST = 16'h4B00,
  parameter logic [WORD_W-1:0] THB_RST = 16'h5000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PTR_W-1:0]   ptr,
  input  logic               wr_en,
  input  logic               wr_idx,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [WORD_W-1:0]  sample_i,
  output logic [WORD_W-1:0]  rd_word,
  output logic [BYTE_W-1:0]  cfg,
  output logic [WORD_W-1:0]  thr_a,
  output logic [WORD_W-1:0]  thr_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= CFG_RST;
      thr_a <= THA_RST;
      thr_b <= THB_RST;
    end else if (wr_en) begin
      unique case (ptr)
        2'd1: cfg <= wr_data;
        2'd2: if (wr_idx) thr_a[BYTE_W-1:0] <= wr_data;
              else        thr_a[WORD_W-1:BYTE_W] <= wr_data;
        2'd3: if (wr_idx) thr_b[BYTE_W-1:0] <= wr_data;
              else        thr_b[WORD_W-1:BYTE_W] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (ptr)
      2'd0:    rd_word = sample_i;
      2'd1:    rd_word = {{(WORD_W-BYTE_W){1'b0}}, cfg};
      2'd2:    rd_word = thr_a;
      default: rd_word = thr_b;
    endcase
  end
endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smbp_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CFG_RST     = 8'h00,
  parameter logic [WORD_W-1:0] THA_RST     = 16'h4B00,
  parameter logic [WORD_W-1:0] THB_RST     = 16'h5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        strap_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic [BYTE_W-1:0] cfg_o,
  output logic [WORD_W-1:0] thr_a_o,
  output logic [WORD_W-1:0] thr_b_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]  ptr;
  logic              wr_en, wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_word;

  smbp_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbp_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap_i(strap_i), .rd_word(rd_word), .sda_oe(sda_oe_o), .ptr(ptr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  smbp_regs #(.CFG_RST(CFG_RST), .THA_RST(THA_RST), .THB_RST(THB_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .ptr(ptr), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sample_i(sample_i), .rd_word(rd_word),
    .cfg(cfg_o), .thr_a(thr_a_o), .thr_b(thr_b_o)
  );
endmodule

// File: rtl/smbp_chk.sv
module smbp_chk
  import smbp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic [PTR_W-1:0] ptr,
  input logic             wr_en
);
  // R3: the pull-down moves only after an SCL fall or a bus condition
  a_r3_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R2: a stop leaves the line released
  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R11: a start leaves the line released
  a_r11_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R5: the pointer changes only at an acknowledge decision
  a_r5_ptr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(scl_fall));

  // R9: a register write is a single-cycle strobe
  a_r9_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R9: a register write follows an SCL fall
  a_r9_wr_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_fall));
endmodule

bind smb_ptr_slave smbp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .ptr(ptr), .wr_en(wr_en)
);

// File: tb/sim_smb_ptr_slave.sv
module sim_smb_ptr_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [2:0]  strap = 3'b101;
  logic [15:0] sample = 16'h1357;
  logic [7:0]  cfg;
  logic [15:0] thr_a, thr_b;

  assign sda_bus = sda_m & ~sda_oe;

  smb_ptr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .sample_i(sample),
    .cfg_o(cfg), .thr_a_o(thr_a), .thr_b_o(thr_b)
  );

  // scoreboard
  int    exp_q[$];
  int    obs_q[$];
  string tag_q[$];
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;

  task automatic chk(input string tag, input int exp, input int act);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    obs_q.push_back(act);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        int e, a;
        string t;
        e = exp_q.pop_front();
        a = obs_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (e != a) begin
          n_bad++;
          $display("FAIL %s: got 0x%0h expected 0x%0h", t, a, e);
        end
      end
    end
  end

  // bus driver
  task automatic hold(); repeat (H) @(negedge clk); endtask
  task automatic bus_start();
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask
  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask
  task automatic put_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = v[i]; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
    end
  endtask
  task automatic send_byte(input logic [7:0] v, output int ack);
    put_bits(v, 8);
    sda_m = 1'b1; hold(); scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = sda_bus ? 0 : 1;
    repeat (H/2) @(negedge clk);
    scl_m = 1'b0;
  endtask
  task automatic read_byte(output int b, input bit mack);
    logic [7:0] v;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      v[i] = sda_bus;
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0;
    end
    b = v;
    sda_m = ~mack; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
  endtask

  localparam logic [7:0] AW = 8'h9A, AR = 8'h9B;

  initial begin
    int a, b;
    repeat (4) @(negedge clk);
    chk("R13 sda_oe reset", 0, sda_oe);
    chk("R13 cfg reset", 8'h00, cfg);
    chk("R13 thr_a reset", 16'h4B00, thr_a);
    chk("R13 thr_b reset", 16'h5000, thr_b);
    rst_n = 1'b1;
    hold();

    // R13 pointer 0 after reset, R7 two-byte read high first, R8 NACK end
    bus_start(); send_byte(AR, a); chk("R1 read address ack", 1, a);
    read_byte(b, 1); chk("R13 ptr0 high", 8'h13, b);
    read_byte(b, 0); chk("R7 ptr0 low", 8'h57, b);
    bus_stop();
    chk("R8 released after NACK", 0, sda_oe);

    // R1 foreign address
    bus_start(); send_byte(8'h92, a); chk("R1 mismatch nack", 0, a);
    send_byte(8'h00, a); chk("R1 stays off bus", 0, a);
    bus_stop();

    // R4 / R9 configuration write
    bus_start(); send_byte(AW, a); chk("R1 write address ack", 1, a);
    send_byte(8'h01, a); chk("R4 pointer ack", 1, a);
    send_byte(8'hA5, a); chk("R9 data ack", 1, a);
    bus_stop();
    chk("R9 cfg written", 8'hA5, cfg);

    // R6 read without pointer cycle, R7 one-byte register
    bus_start(); send_byte(AR, a);
    read_byte(b, 0); chk("R6 cfg read via stored ptr", 8'hA5, b);
    bus_stop();

    // R9 threshold A write, high then low
    bus_start(); send_byte(AW, a); send_byte(8'h02, a);
    send_byte(8'h12, a); send_byte(8'h34, a); chk("R9 low byte ack", 1, a);
    bus_stop();
    chk("R9 thr_a written", 16'h1234, thr_a);

    // R6 pointer set then repeated start read
    bus_start(); send_byte(AW, a); send_byte(8'h03, a);
    bus_start(); send_byte(AR, a); chk("R6 repeated-start addr ack", 1, a);
    read_byte(b, 1); chk("R7 thr_b high", 8'h50, b);
    read_byte(b, 0); chk("R7 thr_b low", 8'h00, b);
    bus_stop();

    // R5 bad pointer
    bus_start(); send_byte(AW, a); send_byte(8'h42, a); chk("R5 bad ptr nack", 0, a);
    send_byte(8'h01, a); chk("R5 abandoned", 0, a);
    bus_stop();
    bus_start(); send_byte(AR, a);
    read_byte(b, 0); chk("R5 ptr kept", 8'h50, b);
    bus_stop();

    // R10 read-only sample register
    sample = 16'hBEEF;
    bus_start(); send_byte(AW, a); send_byte(8'h00, a);
    send_byte(8'h11, a); chk("R10 ro write ack", 1, a);
    send_byte(8'h22, a);
    bus_stop();
    bus_start(); send_byte(AR, a);
    read_byte(b, 1); chk("R10 sample high", 8'hBE, b);
    read_byte(b, 1); chk("R10 sample low", 8'hEF, b);
    read_byte(b, 0); chk("R7 no drive after last byte", 8'hFF, b);
    bus_stop();

    // R12 snapshot across the two bytes
    bus_start(); send_byte(AR, a);
    read_byte(b, 1); chk("R12 snapshot high", 8'hBE, b);
    sample = 16'h0102;
    read_byte(b, 0); chk("R12 snapshot low", 8'hEF, b);
    bus_stop();

    // R11 mid-byte start, then full write
    bus_start(); put_bits(AW, 4);
    bus_start(); send_byte(AW, a); chk("R11 addr after abort", 1, a);
    send_byte(8'h02, a); send_byte(8'h77, a); send_byte(8'h88, a);
    bus_stop();
    chk("R11 thr_a after restart", 16'h7788, thr_a);

    // R11 mid-byte stop keeps pointer
    bus_start(); send_byte(AW, a); put_bits(8'h01, 3);
    bus_stop();
    bus_start(); send_byte(AR, a);
    read_byte(b, 0); chk("R11 ptr kept after stop", 8'h77, b);
    bus_stop();

    // R9 surplus byte discarded
    bus_start(); send_byte(AW, a); send_byte(8'h01, a);
    send_byte(8'h3C, a); send_byte(8'h99, a); chk("R9 surplus ack", 1, a);
    bus_stop();
    chk("R9 surplus discarded", 8'h3C, cfg);
    chk("R3 released at idle", 0, sda_oe);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule